// File: doc/BRIEF.md
# Power-Fail Guarded Memory and Clock Register Bus Decoder

This block connects a byte-wide asynchronous host bus to two targets: a large byte-addressed memory array and a small file of sixteen clock registers. The host drives an active-low memory select, an active-low clock-register select, an active-low write strobe and an active-low output enable. The block samples these lines, together with the address and the incoming data byte, into the system clock domain. From the sampled values it produces read strobes and single-cycle write-commit strobes for each target, and it drives the output side of the data pads.

A write spans the interval in which its select and the write strobe are both low. The write is committed to its target once, at the end of that interval, with the address and data last seen inside it. When both selects are low together, the bus is treated as invalid: nothing is read, written or driven.

A digital power-fail input shuts the block off at once. All strobes stop and the pad drivers are released. Access stays shut for a parameterised number of clock cycles after the synchronised power-fail input clears. Reset is treated in the same way, so the block comes out of reset blocked for the same interval.

Top module: `pfbus_top`

## Requirements
- R1: With memory select low, clock-register select high and write strobe high (after the sampling latency), `memRdEn` is 1. If output enable is also low, `dqOe` is 1 and `dqOut` equals `memRdData`.
- R2: While output enable is high, `dqOe` is 0 in every mode.
- R3: A memory write (memory select low, clock-register select high, write strobe low) produces exactly one one-cycle `memWrEn` pulse, carrying the address and data last sampled during the write. The level of output enable during the write has no effect.
- R4: Clock-register read and write use clock-register select low with memory select high. `regAddr` carries address bits 3:0, and a register write produces exactly one one-cycle `regWrEn` pulse.
- R5: A write window opens when the later of select and write strobe goes low and closes when the earlier of them goes high. No commit occurs while the window is open. The commit uses the data present at the close, not the data present at the open.
- R6: While both selects are low and access is not blocked, `busInvalid` is 1 and all read strobes, write strobes and `dqOe` are 0.
- R7: While `powerFail` is 1, `accessBlocked` is 1 and `dqOe` is 0 in the same cycle, and no strobe is asserted.
- R8: After `powerFail` returns to 0, `accessBlocked` stays 1 through posedge SYNC_STAGES+RECOVERY_CYCLES-1 after the release and clears at posedge SYNC_STAGES+RECOVERY_CYCLES.
- R9: During reset all strobes and `dqOe` are 0 and `accessBlocked` is 1. After reset is released, the recovery interval of R8 applies, counted from the release.
- R10: A write that is cut short by power fail or by an invalid state commits nothing. The target keeps its previous contents.
- R11: Bus inputs take effect SYNC_STAGES clock edges after they change, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| powerFail | input | 1 | High while supply is out of tolerance |
| ceN | input | 1 | Active-low memory select |
| csN | input | 1 | Active-low clock-register select |
| weN | input | 1 | Active-low write strobe |
| oeN | input | 1 | Active-low output enable |
| addrIn | input | 20 | Host address |
| dqIn | input | 8 | Data byte from the pads |
| dqOut | output | 8 | Data byte to the pads |
| dqOe | output | 1 | Pad output enable |
| memAddr | output | 20 | Memory array address |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write commit, one cycle |
| memWrData | output | 8 | Memory write data |
| memRdData | input | 8 | Memory read data |
| regAddr | output | 4 | Clock register index |
| regRdEn | output | 1 | Clock register read strobe |
| regWrEn | output | 1 | Clock register write commit, one cycle |
| regWrData | output | 8 | Clock register write data |
| regRdData | input | 8 | Clock register read data |
| busInvalid | output | 1 | Both selects low |
| accessBlocked | output | 1 | Power-fail or recovery lockout active |

## Verification
The bench targets write windows whose edges come in awkward orders. In one, the write strobe falls before the select and the select rises first. A design that committed at the opening edge, or committed twice, would leave the wrong byte in the array or double the commit count. Other tests let a write degrade into the invalid state, or into a power fail, before it closes. A design that committed on any closing edge would corrupt the stored byte, which a later read exposes. The recovery count is probed one cycle before and one cycle at its expected end, so an off-by-one in the lockout counter or in the synchroniser depth shows up as an early or late strobe.

// File: rtl/pfbus_pkg.sv
package pfbus_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic memRd;
    logic memWr;
    logic regRd;
    logic regWr;
    logic capture;
    logic useHeld;
    logic drive;
    logic selReg;
  } strobe_t;
endpackage

// File: rtl/pfbus_sync.sv
module pfbus_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[g] <= RESET_VAL;
      else if (g == 0) stage[g] <= d;
      else stage[g] <= stage[(g == 0) ? 0 : g - 1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pfbus_ctrl.sv
module pfbus_ctrl
  import pfbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RECOVERY_CYCLES = 6250000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    powerFail,
  input  logic    ceN,
  input  logic    csN,
  input  logic    weN,
  input  logic    oeN,
  output strobe_t strobes,
  output logic    busInvalid,
  output logic    accessBlocked
);
  localparam int CNT_W = $clog2(RECOVERY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RECOVERY_CYCLES);

  logic [4:0] syncOut;
  logic sPf, sCe, sCs, sWe, sOe;
  logic [CNT_W-1:0] recoverCnt;
  logic blocked, invalid;
  logic memWrNow, regWrNow, memRdNow, regRdNow;
  logic wasMemWr, wasRegWr;

  pfbus_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RESET_VAL(5'h1F)) uCtlSync (
    .clk(clk), .rstN(rstN),
    .d({powerFail, ceN, csN, weN, oeN}),
    .q(syncOut)
  );
  assign {sPf, sCe, sCs, sWe, sOe} = syncOut;

  // lockout counter: reloaded while failed, drains afterwards
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) recoverCnt <= CNT_LOAD;
    else if (sPf) recoverCnt <= CNT_LOAD;
    else if (recoverCnt != '0) recoverCnt <= recoverCnt - 1'b1;
  end

  assign blocked  = powerFail | sPf | (recoverCnt != '0);
  assign invalid  = !blocked && !sCe && !sCs;

  assign memWrNow = !blocked && sCs && !sCe && !sWe;
  assign regWrNow = !blocked && !sCs && sCe && !sWe;
  assign memRdNow = !blocked && sCs && !sCe && sWe;
  assign regRdNow = !blocked && !sCs && sCe && sWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wasMemWr <= 1'b0;
      wasRegWr <= 1'b0;
    end else begin
      wasMemWr <= memWrNow;
      wasRegWr <= regWrNow;
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.memRd   = memRdNow;
    strobes.regRd   = regRdNow;
    strobes.memWr   = wasMemWr && !memWrNow && !blocked && !invalid;
    strobes.regWr   = wasRegWr && !regWrNow && !blocked && !invalid;
    strobes.capture = memWrNow | regWrNow;
    strobes.useHeld = strobes.memWr | strobes.regWr;
    strobes.drive   = (memRdNow | regRdNow) && !sOe;
    strobes.selReg  = regRdNow;
  end

  assign busInvalid    = invalid;
  assign accessBlocked = blocked;
endmodule

// File: rtl/pfbus_dp.sv
module pfbus_dp
  import pfbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int REG_ADDR_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobes,
  input  logic [ADDR_W-1:0]     addrIn,
  input  logic [DATA_W-1:0]     dqIn,
  input  logic [DATA_W-1:0]     memRdData,
  input  logic [DATA_W-1:0]     regRdData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [REG_ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     dqOut,
  output logic                  dqOe
);
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [BUS_W-1:0]  syncBus;
  logic [ADDR_W-1:0] sAddr, heldAddr, curAddr;
  logic [DATA_W-1:0] sData, heldData;

  pfbus_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) uBusSync (
    .clk(clk), .rstN(rstN),
    .d({addrIn, dqIn}),
    .q(syncBus)
  );
  assign {sAddr, sData} = syncBus;

  // hold the last in-window address and data for the commit cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
      heldData <= '0;
    end else if (strobes.capture) begin
      heldAddr <= sAddr;
      heldData <= sData;
    end
  end

  assign curAddr = strobes.useHeld ? heldAddr : sAddr;
  assign memAddr = curAddr;
  assign regAddr = curAddr[REG_ADDR_W-1:0];
  assign wrData  = heldData;
  assign dqOut   = strobes.selReg ? regRdData : memRdData;
  assign dqOe    = strobes.drive;
endmodule

// File: rtl/pfbus_top.sv
module pfbus_top
  import pfbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int REG_ADDR_W = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RECOVERY_CYCLES = 6250000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  powerFail,
  input  logic                  ceN,
  input  logic                  csN,
  input  logic                  weN,
  input  logic                  oeN,
  input  logic [ADDR_W-1:0]     addrIn,
  input  logic [DATA_W-1:0]     dqIn,
  output logic [DATA_W-1:0]     dqOut,
  output logic                  dqOe,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memRdEn,
  output logic                  memWrEn,
  output logic [DATA_W-1:0]     memWrData,
  input  logic [DATA_W-1:0]     memRdData,
  output logic [REG_ADDR_W-1:0] regAddr,
  output logic                  regRdEn,
  output logic                  regWrEn,
  output logic [DATA_W-1:0]     regWrData,
  input  logic [DATA_W-1:0]     regRdData,
  output logic                  busInvalid,
  output logic                  accessBlocked
);
  strobe_t strobes;
  logic [DATA_W-1:0] wrData;

  pfbus_ctrl #(.SYNC_STAGES(SYNC_STAGES), .RECOVERY_CYCLES(RECOVERY_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .powerFail(powerFail),
    .ceN(ceN), .csN(csN), .weN(weN), .oeN(oeN),
    .strobes(strobes), .busInvalid(busInvalid), .accessBlocked(accessBlocked)
  );

  pfbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR_W(REG_ADDR_W),
             .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .addrIn(addrIn), .dqIn(dqIn),
    .memRdData(memRdData), .regRdData(regRdData),
    .memAddr(memAddr), .regAddr(regAddr), .wrData(wrData),
    .dqOut(dqOut), .dqOe(dqOe)
  );

  assign memRdEn   = strobes.memRd;
  assign memWrEn   = strobes.memWr;
  assign regRdEn   = strobes.regRd;
  assign regWrEn   = strobes.regWr;
  assign memWrData = wrData;
  assign regWrData = wrData;
endmodule

// File: rtl/pfbus_checker.sv
module pfbus_checker (
  input logic clk,
  input logic rstN,
  input logic powerFail,
  input logic memWrEn,
  input logic regWrEn,
  input logic memRdEn,
  input logic regRdEn,
  input logic dqOe,
  input logic busInvalid,
  input logic accessBlocked
);
  assert_quiet_when_blocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    accessBlocked |-> !(memWrEn || regWrEn || memRdEn || regRdEn || dqOe));

  assert_release_pads_on_fail_R7: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |-> !dqOe);

  assert_lockout_persists_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(powerFail) |-> accessBlocked);

  assert_invalid_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    busInvalid |-> !(memWrEn || regWrEn || memRdEn || regRdEn || dqOe));

  assert_one_write_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWrEn, regWrEn}));

  assert_one_read_target_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRdEn, regRdEn}));

  assert_mem_commit_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);

  assert_reg_commit_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);
endmodule

bind pfbus_top pfbus_checker uChk (
  .clk(clk), .rstN(rstN), .powerFail(powerFail),
  .memWrEn(memWrEn), .regWrEn(regWrEn), .memRdEn(memRdEn), .regRdEn(regRdEn),
  .dqOe(dqOe), .busInvalid(busInvalid), .accessBlocked(accessBlocked)
);

// File: tb/tb_pfbus_top.sv
module tb_pfbus_top;
  localparam int REC = 20;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerFail = 1'b0;
  logic ceN = 1'b1, csN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [19:0] addrIn = '0;
  logic [7:0] dqIn = '0;
  logic [7:0] dqOut, memWrData, regWrData, memRdData, regRdData;
  logic dqOe, memRdEn, memWrEn, regRdEn, regWrEn, busInvalid, accessBlocked;
  logic [19:0] memAddr;
  logic [3:0] regAddr;

  int checks = 0;
  int failures = 0;
  int memCommits = 0;
  int regCommits = 0;
  logic [19:0] lastMemAddr = '0;
  logic [7:0] lastMemData = '0;
  logic [3:0] lastRegAddr = '0;
  logic [7:0] lastRegData = '0;
  logic [7:0] memModel [256];
  logic [7:0] regModel [16];
  bit done = 1'b0;

  always #10 clk = ~clk;

  pfbus_top #(.SYNC_STAGES(SYNC), .RECOVERY_CYCLES(REC)) dut (
    .clk(clk), .rstN(rstN), .powerFail(powerFail),
    .ceN(ceN), .csN(csN), .weN(weN), .oeN(oeN),
    .addrIn(addrIn), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe),
    .memAddr(memAddr), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .memWrData(memWrData), .memRdData(memRdData),
    .regAddr(regAddr), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .busInvalid(busInvalid), .accessBlocked(accessBlocked)
  );

  // target models
  assign memRdData = memModel[memAddr[7:0]];
  assign regRdData = regModel[regAddr];

  always @(posedge clk) begin
    if (memWrEn) begin
      memModel[memAddr[7:0]] <= memWrData;
      memCommits <= memCommits + 1;
      lastMemAddr <= memAddr;
      lastMemData <= memWrData;
    end
    if (regWrEn) begin
      regModel[regAddr] <= regWrData;
      regCommits <= regCommits + 1;
      lastRegAddr <= regAddr;
      lastRegData <= regWrData;
    end
  end

  // ceN csN weN oeN | memRd regRd invalid oe
  localparam int NV = 11;
  localparam logic [7:0] VEC [NV] = '{
    8'b1111_0000,  // idle
    8'b0110_1001,  // memory read, driven (R1)
    8'b0111_1000,  // memory read, oe high (R2)
    8'b1010_0101,  // register read, driven (R4)
    8'b1011_0100,  // register read, oe high (R2)
    8'b0100_0000,  // memory write, oe low ignored (R3)
    8'b1000_0000,  // register write (R4)
    8'b0010_0010,  // both selects, read (R6)
    8'b0000_0010,  // both selects, write (R6)
    8'b1110_0000,  // no select, oe low
    8'b0011_0010   // both selects, oe high (R6)
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setBus(input logic ce, input logic cs, input logic we, input logic oe);
    ceN = ce; csN = cs; weN = we; oeN = oe;
  endtask

  task automatic busWrite(input logic ce, input logic cs, input logic [19:0] a, input logic [7:0] d);
    addrIn = a; dqIn = d; ceN = ce; csN = cs; oeN = 1'b1;
    cyc(2);
    weN = 1'b0;
    cyc(4);
    weN = 1'b1;
    cyc(2);
    ceN = 1'b1; csN = 1'b1;
    cyc(4);
  endtask

  task automatic waitRecovery();
    cyc(SYNC + REC + 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) memModel[i] = '0;
    for (int i = 0; i < 16; i++) regModel[i] = '0;
  end

  initial begin
    int mc;
    // R9: reset state
    cyc(3);
    check("R9 blocked in reset", accessBlocked, 1);
    check("R9 no strobes in reset", {memRdEn, memWrEn, regRdEn, regWrEn, dqOe}, 0);
    rstN = 1'b1;
    cyc(SYNC + REC - 1);
    check("R9 still blocked before end", accessBlocked, 1);
    cyc(1);
    check("R9 unblocked at end", accessBlocked, 0);

    // decode table: R1 R2 R4 R6
    for (int v = 0; v < NV; v++) begin
      setBus(VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4]);
      cyc(SYNC + 1);
      check($sformatf("R1/R2/R4/R6 decode vec %0d", v),
            {memRdEn, regRdEn, busInvalid, dqOe}, VEC[v][3:0]);
      setBus(1, 1, 1, 1);
      cyc(SYNC + 3);
    end

    // R3: memory write with oe low during write, then read back (R1)
    mc = memCommits;
    addrIn = 20'h12345; dqIn = 8'hA5; ceN = 0; oeN = 0; cyc(2);
    weN = 0; cyc(4); weN = 1; cyc(2); ceN = 1; oeN = 1; cyc(4);
    check("R3 one memory commit", memCommits - mc, 1);
    check("R3 commit address", lastMemAddr, 20'h12345);
    check("R3 commit data", lastMemData, 8'hA5);
    addrIn = 20'h12345; setBus(0, 1, 1, 0); cyc(SYNC + 1);
    check("R1 read drives pads", dqOe, 1);
    check("R1 read data", dqOut, 8'hA5);
    setBus(1, 1, 1, 1); cyc(4);

    // R4: register write uses low address nibble, then read back
    mc = regCommits;
    busWrite(1, 0, 20'hABCD7, 8'h3C);
    check("R4 one register commit", regCommits - mc, 1);
    check("R4 register index", lastRegAddr, 4'h7);
    check("R4 register data", lastRegData, 8'h3C);
    addrIn = 20'h00017; setBus(1, 0, 1, 0); cyc(SYNC + 1);
    check("R4 register read data", dqOut, 8'h3C);
    check("R4 no memory read strobe", memRdEn, 0);
    setBus(1, 1, 1, 1); cyc(4);

    // R5: we falls first, select rises first; data changes in window
    mc = memCommits;
    addrIn = 20'h00042; dqIn = 8'h11; weN = 0; cyc(3);
    ceN = 0; cyc(4);
    check("R5 no commit while open", memCommits - mc, 0);
    dqIn = 8'h22; cyc(4);
    check("R5 no commit after data change", memCommits - mc, 0);
    ceN = 1; cyc(SYNC + 2);
    check("R5 commit at earlier rise", memCommits - mc, 1);
    check("R5 data at close", lastMemData, 8'h22);
    weN = 1; cyc(4);
    check("R5 no second commit", memCommits - mc, 1);

    // R11: latency of sampled controls
    addrIn = 20'h12345; setBus(0, 1, 1, 1);
    cyc(SYNC - 1);
    check("R11 not yet decoded", memRdEn, 0);
    cyc(1);
    check("R11 decoded after sync", memRdEn, 1);
    setBus(1, 1, 1, 1); cyc(4);

    // R10: write degraded into invalid state
    mc = memCommits;
    addrIn = 20'h12345; dqIn = 8'h77; ceN = 0; cyc(2);
    weN = 0; cyc(4);
    csN = 0; cyc(SYNC + 1);
    check("R6 invalid flagged", busInvalid, 1);
    setBus(1, 1, 1, 1); cyc(6);
    check("R10 invalid write discarded", memCommits - mc, 0);

    // R7/R8/R10: power fail during a write, then recovery
    dqIn = 8'h99; ceN = 0; cyc(2);
    weN = 0; cyc(4);
    powerFail = 1; #1;
    check("R7 blocked at once", accessBlocked, 1);
    cyc(2);
    setBus(1, 1, 1, 1); cyc(3);
    check("R10 power-fail write discarded", memCommits - mc, 0);
    // hold a driven read across the release
    setBus(0, 1, 1, 0); cyc(3);
    check("R7 no drive during fail", {dqOe, memRdEn}, 0);
    powerFail = 0;
    cyc(SYNC + REC - 1);
    check("R8 blocked before end", {accessBlocked, memRdEn}, 2'b10);
    cyc(1);
    check("R8 read resumes", {accessBlocked, memRdEn, dqOe}, 3'b011);
    check("R10 memory kept", dqOut, 8'hA5);
    powerFail = 1; #1;
    check("R7 pads released at once", dqOe, 0);
    powerFail = 0; setBus(1, 1, 1, 1);
    waitRecovery();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule